// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block sits beside the command bus of a four-bank synchronous DRAM and watches each decoded command as it arrives. It keeps a small model of every bank (open or closed, plus the cycles left in each timing window) and flags, in the same cycle, any command that comes too soon after an earlier one or that targets a bank in the wrong state. It also notices a bank left open longer than the row-active maximum.

All spacing limits are given as times in picoseconds together with the clock period. The block turns each of them into a whole number of cycles by rounding up. Only command spacing is checked. Data pins, refresh scheduling and electrical limits are left to other blocks.

Command codes on `cmdCode`: 0 no-op, 1 open bank (activate), 2 close one bank, 3 close all banks, 4 read, 5 read with auto-close, 6 write, 7 write with auto-close, 8 auto refresh, 9 self refresh, 10 load mode register. Codes 11 to 15 are no-ops.

Violation codes on `violType`: 0 illegal bank state, 1 open-to-access too short, 2 row-active minimum broken, 3 close-to-open too short, 4 row cycle too short, 5 bank-to-bank open spacing too short, 6 mode-register settle too short, 7 row-active maximum exceeded.

Top module: `sdram_cmd_timing_chk`

## Requirements
- R1: After reset all banks are closed and every timing window has expired, so an open to any bank raises no violation and a read to any bank raises code 0.
- R2: With `cmdValid` high, a command that breaks a rule drives `violValid` high in that same cycle, with its code on `violType` and a bank on `violBank`. At most one violation is reported per cycle.
- R3: Code 0 is raised for a read, write, auto-close access or single close to a closed bank, for an open to an already open bank, and for auto refresh, self refresh or mode load while any bank is open. For these all-bank commands the lowest open bank is reported.
- R4: A read or write (plain or auto-close) to a bank fewer than ceil(tRCD/tCK) cycles after that bank's open raises code 1.
- R5: A single close, or a close-all covering an open bank, fewer than ceil(tRASmin/tCK) cycles after that bank's open raises code 2. An auto-close read or write that meets R4 but comes earlier than this raises code 2 as well.
- R6: An open to a bank fewer than ceil(tRP/tCK) cycles after that bank was closed (by close, close-all or an auto-close access) raises code 3. The same applies to refresh, self refresh and mode load against any bank.
- R7: An open to a bank fewer than ceil(tRC/tCK) cycles after the last open of that bank or after any refresh raises code 4. The same applies to refresh, self refresh and mode load against any bank.
- R8: Two opens, to any banks, fewer than ceil(tRRD/tCK) cycles apart raise code 5 on the second one.
- R9: An open, refresh, self refresh or mode load fewer than ceil(tRSA/tCK) cycles after a mode load raises code 6, reported on the command's bank.
- R10: A bank still open ceil(tRASmax/tCK)+1 cycles after its open raises code 7 for that bank in exactly that cycle, and only once.
- R11: Within one command the checks rank: state, mode settle, row cycle, close-to-open, bank-to-bank, open-to-access, row-active minimum. A command violation takes precedence over a timeout in the same cycle, and that timeout is then not reported.
- R12: A valid command updates the bank model even when it is flagged. When `cmdValid` is low, or the code is a no-op or unused, no state changes and nothing is flagged except a timeout.
- R13: Each window length is derived as ceil(time / clock period). With the defaults (8 ns clock) these are 3, 6, 12500, 3, 9, 2 and 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | The command fields are valid this cycle |
| cmdCode | input | 4 | Decoded command code |
| cmdBank | input | 2 | Target bank |
| violValid | output | 1 | A violation is reported this cycle |
| violType | output | 3 | Violation code |
| violBank | output | 2 | Bank involved in the violation |

## Verification
The hardest case to reach is the row-active timeout. It appears only after more than twelve thousand idle cycles with a bank open, and it is harder still when it coincides with an offending command. The bench opens a bank, drives no-ops through the whole window and checks the cycle before the limit, the limit cycle and the cycle after it. It then repeats the run with an illegal read placed on the limit cycle, to show that the command takes precedence and that the timeout does not come back later. A table of commands first moves each bank through each window with gaps counted out by hand, so that every rule is hit one cycle too early.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  localparam int BANKS  = 4;
  localparam int BANK_W = $clog2(BANKS);

  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_OPEN      = 4'd1,
    CMD_CLOSE     = 4'd2,
    CMD_CLOSE_ALL = 4'd3,
    CMD_RD        = 4'd4,
    CMD_RD_AC     = 4'd5,
    CMD_WR        = 4'd6,
    CMD_WR_AC     = 4'd7,
    CMD_AUTO_REF  = 4'd8,
    CMD_SELF_REF  = 4'd9,
    CMD_LOAD_MODE = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    VIOL_STATE      = 3'd0,
    VIOL_ACCESS     = 3'd1,
    VIOL_ROW_MIN    = 3'd2,
    VIOL_PRECHARGE  = 3'd3,
    VIOL_ROW_CYCLE  = 3'd4,
    VIOL_BANK_GAP   = 3'd5,
    VIOL_MODE_WAIT  = 3'd6,
    VIOL_ROW_EXPIRE = 3'd7
  } viol_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [BANKS-1:0] openB;
    logic [BANKS-1:0] closeB;
    logic             refAll;
    logic             modeSet;
  } strobe_t;

  // window state from datapath to control
  typedef struct packed {
    logic [BANKS-1:0] isOpen;
    logic [BANKS-1:0] accessOk;
    logic [BANKS-1:0] rowMinOk;
    logic [BANKS-1:0] precOk;
    logic [BANKS-1:0] cycleOk;
    logic [BANKS-1:0] timedOut;
    logic             actGapOk;
    logic             modeOk;
  } status_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [BANK_W-1:0] lowIdx(input logic [BANKS-1:0] m);
    logic [BANK_W-1:0] idx;
    idx = '0;
    for (int i = BANKS - 1; i >= 0; i--) begin
      if (m[i]) idx = BANK_W'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/sdram_chk_datapath.sv
module sdram_chk_datapath
  import sdram_chk_pkg::*;
#(
  parameter int RCD_CYC    = 3,
  parameter int RASMIN_CYC = 6,
  parameter int RASMAX_CYC = 12500,
  parameter int RP_CYC     = 3,
  parameter int RC_CYC     = 9,
  parameter int RRD_CYC    = 2,
  parameter int RSA_CYC    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t st,
  output status_t stat
);

  localparam int SMAX = maxInt(maxInt(maxInt(RCD_CYC, RASMIN_CYC), maxInt(RP_CYC, RC_CYC)),
                               maxInt(RRD_CYC, RSA_CYC));
  localparam int CW = $clog2(SMAX + 2);
  localparam int AW = $clog2(RASMAX_CYC + 3);

  localparam logic [CW-1:0] RCD_LD    = CW'(RCD_CYC - 1);
  localparam logic [CW-1:0] RASMIN_LD = CW'(RASMIN_CYC - 1);
  localparam logic [CW-1:0] RP_LD     = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] RC_LD     = CW'(RC_CYC - 1);
  localparam logic [CW-1:0] RRD_LD    = CW'(RRD_CYC - 1);
  localparam logic [CW-1:0] RSA_LD    = CW'(RSA_CYC - 1);
  localparam logic [AW-1:0] AGE_HIT   = AW'(RASMAX_CYC + 1);
  localparam logic [AW-1:0] AGE_TOP   = AW'(RASMAX_CYC + 2);

  logic [BANKS-1:0] isOpenV, accessOkV, rowMinOkV, precOkV, cycleOkV, tmoV;
  logic [CW-1:0]    gapCnt, modeCnt;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic          openQ;
    logic [CW-1:0] rcdCnt, rasCnt, rpCnt, rcCnt;
    logic [AW-1:0] ageCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ  <= 1'b0;
        rcdCnt <= '0;
        rasCnt <= '0;
        rpCnt  <= '0;
        rcCnt  <= '0;
        ageCnt <= '0;
      end else begin
        if (st.openB[b])       openQ <= 1'b1;
        else if (st.closeB[b]) openQ <= 1'b0;

        if (st.openB[b])        rcdCnt <= RCD_LD;
        else if (rcdCnt != '0)  rcdCnt <= rcdCnt - 1'b1;

        if (st.openB[b])        rasCnt <= RASMIN_LD;
        else if (rasCnt != '0)  rasCnt <= rasCnt - 1'b1;

        if (st.closeB[b])       rpCnt <= RP_LD;
        else if (rpCnt != '0)   rpCnt <= rpCnt - 1'b1;

        if (st.openB[b] || st.refAll) rcCnt <= RC_LD;
        else if (rcCnt != '0)         rcCnt <= rcCnt - 1'b1;

        if (st.openB[b])                      ageCnt <= AW'(1);
        else if (st.closeB[b])                ageCnt <= '0;
        else if (openQ && ageCnt != AGE_TOP)  ageCnt <= ageCnt + 1'b1;
      end
    end

    assign isOpenV[b]   = openQ;
    assign accessOkV[b] = (rcdCnt == '0);
    assign rowMinOkV[b] = (rasCnt == '0);
    assign precOkV[b]   = (rpCnt == '0);
    assign cycleOkV[b]  = (rcCnt == '0);
    assign tmoV[b]      = openQ && (ageCnt == AGE_HIT);

    assert_open_after_act_R12: assert property (@(posedge clk) disable iff (!rstN)
      st.openB[b] |=> isOpenV[b]);
    assert_close_shuts_R6: assert property (@(posedge clk) disable iff (!rstN)
      st.closeB[b] && !st.openB[b] |=> !isOpenV[b] && ((RP_CYC < 2) || !precOkV[b]));
    assert_timeout_once_R10: assert property (@(posedge clk) disable iff (!rstN)
      tmoV[b] |=> !tmoV[b]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      modeCnt <= '0;
    end else begin
      if (|st.openB)          gapCnt <= RRD_LD;
      else if (gapCnt != '0)  gapCnt <= gapCnt - 1'b1;

      if (st.modeSet)         modeCnt <= RSA_LD;
      else if (modeCnt != '0) modeCnt <= modeCnt - 1'b1;
    end
  end

  assign stat = '{isOpen:   isOpenV,
                  accessOk: accessOkV,
                  rowMinOk: rowMinOkV,
                  precOk:   precOkV,
                  cycleOk:  cycleOkV,
                  timedOut: tmoV,
                  actGapOk: (gapCnt == '0),
                  modeOk:   (modeCnt == '0)};

  assert_gap_opens_R8: assert property (@(posedge clk) disable iff (!rstN)
    (RRD_CYC > 1) && (|st.openB) |=> !stat.actGapOk);

endmodule

// File: rtl/sdram_chk_ctrl.sv
module sdram_chk_ctrl
  import sdram_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdCode,
  input  logic [BANK_W-1:0] cmdBank,
  input  status_t           stat,
  output strobe_t           st,
  output logic              violValid,
  output logic [2:0]        violType,
  output logic [BANK_W-1:0] violBank
);

  logic [BANKS-1:0]  bankOh;
  logic              hit;
  viol_e             kind;
  logic [BANK_W-1:0] vb;

  assign bankOh = BANKS'(1) << cmdBank;

  always_comb begin
    st   = '0;
    hit  = 1'b0;
    kind = VIOL_STATE;
    vb   = cmdBank;
    if (cmdValid) begin
      case (cmd_e'(cmdCode))
        CMD_OPEN: begin
          st.openB = bankOh;
          if (stat.isOpen[cmdBank])         begin hit = 1'b1; kind = VIOL_STATE;     end
          else if (!stat.modeOk)            begin hit = 1'b1; kind = VIOL_MODE_WAIT; end
          else if (!stat.cycleOk[cmdBank])  begin hit = 1'b1; kind = VIOL_ROW_CYCLE; end
          else if (!stat.precOk[cmdBank])   begin hit = 1'b1; kind = VIOL_PRECHARGE; end
          else if (!stat.actGapOk)          begin hit = 1'b1; kind = VIOL_BANK_GAP;  end
        end
        CMD_RD, CMD_WR: begin
          if (!stat.isOpen[cmdBank])        begin hit = 1'b1; kind = VIOL_STATE;  end
          else if (!stat.accessOk[cmdBank]) begin hit = 1'b1; kind = VIOL_ACCESS; end
        end
        CMD_RD_AC, CMD_WR_AC: begin
          st.closeB = bankOh;
          if (!stat.isOpen[cmdBank])        begin hit = 1'b1; kind = VIOL_STATE;   end
          else if (!stat.accessOk[cmdBank]) begin hit = 1'b1; kind = VIOL_ACCESS;  end
          else if (!stat.rowMinOk[cmdBank]) begin hit = 1'b1; kind = VIOL_ROW_MIN; end
        end
        CMD_CLOSE: begin
          st.closeB = bankOh;
          if (!stat.isOpen[cmdBank])        begin hit = 1'b1; kind = VIOL_STATE;   end
          else if (!stat.rowMinOk[cmdBank]) begin hit = 1'b1; kind = VIOL_ROW_MIN; end
        end
        CMD_CLOSE_ALL: begin
          st.closeB = '1;
          if (|(stat.isOpen & ~stat.rowMinOk)) begin
            hit = 1'b1; kind = VIOL_ROW_MIN; vb = lowIdx(stat.isOpen & ~stat.rowMinOk);
          end
        end
        CMD_AUTO_REF, CMD_SELF_REF, CMD_LOAD_MODE: begin
          st.refAll  = (cmd_e'(cmdCode) != CMD_LOAD_MODE);
          st.modeSet = (cmd_e'(cmdCode) == CMD_LOAD_MODE);
          if (|stat.isOpen) begin
            hit = 1'b1; kind = VIOL_STATE; vb = lowIdx(stat.isOpen);
          end else if (!stat.modeOk) begin
            hit = 1'b1; kind = VIOL_MODE_WAIT;
          end else if (|(~stat.cycleOk)) begin
            hit = 1'b1; kind = VIOL_ROW_CYCLE; vb = lowIdx(~stat.cycleOk);
          end else if (|(~stat.precOk)) begin
            hit = 1'b1; kind = VIOL_PRECHARGE; vb = lowIdx(~stat.precOk);
          end
        end
        default: ;
      endcase
    end
    if (!hit && (|stat.timedOut)) begin
      hit  = 1'b1;
      kind = VIOL_ROW_EXPIRE;
      vb   = lowIdx(stat.timedOut);
    end
  end

  assign violValid = hit;
  assign violType  = kind;
  assign violBank  = vb;

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !(|stat.timedOut)) |-> !violValid);
  assert_single_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st.openB));
  assert_cmd_first_R11: assert property (@(posedge clk) disable iff (!rstN)
    (violValid && violType != VIOL_ROW_EXPIRE) |-> cmdValid);

endmodule

// File: rtl/sdram_cmd_timing_chk.sv
module sdram_cmd_timing_chk
  import sdram_chk_pkg::*;
#(
  parameter int CLK_PS        = 8000,
  parameter int T_RCD_PS      = 20000,
  parameter int T_RAS_MIN_PS  = 48000,
  parameter int T_RAS_MAX_PS  = 100000000,
  parameter int T_RP_PS       = 20000,
  parameter int T_RC_PS       = 68000,
  parameter int T_RRD_PS      = 16000,
  parameter int T_RSA_PS      = 16000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [3:0] cmdCode,
  input  logic [1:0] cmdBank,
  output logic       violValid,
  output logic [2:0] violType,
  output logic [1:0] violBank
);

  // R13: every window is rounded up to whole cycles
  localparam int RCD_CYC    = (T_RCD_PS     + CLK_PS - 1) / CLK_PS;
  localparam int RASMIN_CYC = (T_RAS_MIN_PS + CLK_PS - 1) / CLK_PS;
  localparam int RASMAX_CYC = (T_RAS_MAX_PS + CLK_PS - 1) / CLK_PS;
  localparam int RP_CYC     = (T_RP_PS      + CLK_PS - 1) / CLK_PS;
  localparam int RC_CYC     = (T_RC_PS      + CLK_PS - 1) / CLK_PS;
  localparam int RRD_CYC    = (T_RRD_PS     + CLK_PS - 1) / CLK_PS;
  localparam int RSA_CYC    = (T_RSA_PS     + CLK_PS - 1) / CLK_PS;

  strobe_t st;
  status_t stat;

  sdram_chk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode),
    .cmdBank   (cmdBank),
    .stat      (stat),
    .st        (st),
    .violValid (violValid),
    .violType  (violType),
    .violBank  (violBank)
  );

  sdram_chk_datapath #(
    .RCD_CYC    (RCD_CYC),
    .RASMIN_CYC (RASMIN_CYC),
    .RASMAX_CYC (RASMAX_CYC),
    .RP_CYC     (RP_CYC),
    .RC_CYC     (RC_CYC),
    .RRD_CYC    (RRD_CYC),
    .RSA_CYC    (RSA_CYC)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .st   (st),
    .stat (stat)
  );

endmodule

// File: tb/sim_sdram_cmd_timing_chk.sv
module sim_sdram_cmd_timing_chk;

  // R13: expected windows from an 8 ns clock
  localparam int ROW_MAX = (100000000 + 8000 - 1) / 8000;

  localparam logic [3:0] C_NOP = 4'd0,  C_OPEN = 4'd1, C_CLOSE = 4'd2, C_CALL = 4'd3;
  localparam logic [3:0] C_RD  = 4'd4,  C_RDAC = 4'd5, C_WR    = 4'd6, C_WRAC = 4'd7;
  localparam logic [3:0] C_REF = 4'd8,  C_SREF = 4'd9, C_MODE  = 4'd10;
  localparam logic [2:0] T_ST = 3'd0, T_ACC = 3'd1, T_RMIN = 3'd2, T_PRE = 3'd3;
  localparam logic [2:0] T_CYC = 3'd4, T_GAP = 3'd5, T_MODE = 3'd6, T_EXP = 3'd7;
  localparam logic [1:0] B0 = 2'd0, B1 = 2'd1, B2 = 2'd2, B3 = 2'd3;
  localparam logic       V1 = 1'b1, V0 = 1'b0;

  // {valid, code, bank, expValid, expType, expBank}
  localparam int NVEC = 50;
  localparam logic [12:0] VEC [NVEC] = '{
    {V1, C_RD,   B0, V1, T_ST,   B0},  // 0  read closed bank
    {V1, C_OPEN, B0, V0, T_ST,   B0},  // 1
    {V1, C_OPEN, B1, V1, T_GAP,  B1},  // 2  bank-to-bank gap
    {V1, C_RD,   B0, V1, T_ACC,  B0},  // 3  open-to-access
    {V1, C_WR,   B0, V0, T_ST,   B0},  // 4  exactly at limit
    {V1, C_CLOSE,B0, V1, T_RMIN, B0},  // 5
    {V1, C_OPEN, B0, V1, T_CYC,  B0},  // 6  row cycle ranks over close-to-open
    {V1, C_MODE, B0, V1, T_ST,   B0},  // 7  banks open
    {V1, C_OPEN, B2, V1, T_MODE, B2},  // 8
    {V1, C_CALL, B0, V1, T_RMIN, B0},  // 9
    {V1, C_RDAC, B1, V1, T_ST,   B1},  // 10
    {V1, C_REF,  B0, V1, T_CYC,  B0},  // 11
    {V0, C_RD,   B0, V0, T_ST,   B0},  // 12 not valid
    {V1, 4'd12,  B0, V0, T_ST,   B0},  // 13 unused code
    {V1, 4'd15,  B1, V0, T_ST,   B0},  // 14 unused code
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_OPEN, B3, V0, T_ST,   B0},  // 20
    {V1, C_OPEN, B3, V1, T_ST,   B3},  // 21 open an open bank
    {V1, C_OPEN, B2, V1, T_GAP,  B2},  // 22 gap reloaded by flagged open
    {V1, C_WRAC, B2, V1, T_ACC,  B2},  // 23
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_CLOSE,B3, V0, T_ST,   B0},  // 30
    {V1, C_OPEN, B3, V1, T_PRE,  B3},  // 31
    {V1, C_RD,   B3, V1, T_ACC,  B3},  // 32
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_RDAC, B3, V1, T_RMIN, B3},  // 34 auto-close early
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_REF,  B0, V1, T_CYC,  B3},  // 37
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_NOP,  B0, V0, T_ST,   B0},
    {V1, C_MODE, B0, V0, T_ST,   B0},  // 46
    {V1, C_MODE, B1, V1, T_MODE, B1},  // 47
    {V1, C_SREF, B0, V1, T_MODE, B0},  // 48
    {V1, C_OPEN, B1, V1, T_CYC,  B1}   // 49 row cycle after self refresh
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [3:0] cmdCode = '0;
  logic [1:0] cmdBank = '0;
  logic       violValid;
  logic [2:0] violType;
  logic [1:0] violBank;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_timing_chk u0 (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode),
    .cmdBank   (cmdBank),
    .violValid (violValid),
    .violType  (violType),
    .violBank  (violBank)
  );

  function automatic string tagOf(input logic ev, input logic [2:0] et);
    if (!ev) return "R12";
    case (et)
      T_ST:   return "R3";
      T_ACC:  return "R4";
      T_RMIN: return "R5";
      T_PRE:  return "R6";
      T_CYC:  return "R7";
      T_GAP:  return "R8";
      T_MODE: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input logic v, input logic [3:0] c, input logic [1:0] b,
                      input logic ev, input logic [2:0] et, input logic [1:0] eb,
                      input string tag);
    @(negedge clk);
    cmdValid = v;
    cmdCode  = c;
    cmdBank  = b;
    #5;
    checks++;
    if (violValid !== ev || (ev && (violType !== et || violBank !== eb))) begin
      errors++;
      $display("FAIL %s: actual v=%0b type=%0d bank=%0d, expected v=%0b type=%0d bank=%0d",
               tag, violValid, violType, violBank, ev, et, eb);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cmdValid = 1'b0;
    cmdCode = C_NOP;
    repeat (2) @(negedge clk);
    #5;
    checks++;
    if (violValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual v=%0b during reset, expected v=0", violValid);
    end
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    // R2..R9, R11, R12: table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12], VEC[i][11:8], VEC[i][7:6], VEC[i][5], VEC[i][4:2], VEC[i][1:0],
           $sformatf("%s R2 vec%0d", tagOf(VEC[i][5], VEC[i][4:2]), i));
    end

    // R1: reset clears the open bank and all windows
    doReset();
    step(V1, C_RD,   B1, V1, T_ST, B1, "R1");
    step(V1, C_OPEN, B1, V0, T_ST, B0, "R1");

    // R10 R13: timeout at exactly limit+1 cycles, only once
    doReset();
    step(V1, C_OPEN, B2, V0, T_ST, B0, "R10");
    for (int k = 1; k <= ROW_MAX + 2; k++) begin
      step(V1, C_NOP, B0, (k == ROW_MAX + 1), T_EXP, B2, "R10 R13");
    end

    // R11: a command violation on the limit cycle wins, the timeout is dropped
    doReset();
    step(V1, C_OPEN, B2, V0, T_ST, B0, "R11");
    for (int k = 1; k <= ROW_MAX; k++) begin
      step(V1, C_NOP, B0, V0, T_ST, B0, "R11");
    end
    step(V1, C_RD,  B0, V1, T_ST, B0, "R11");
    step(V1, C_NOP, B0, V0, T_ST, B0, "R11 R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12: watchdog expired, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule